// File: doc/BRIEF.md
# Sticky Round-Robin Channel Arbiter with Exclusive Hold

This block decides which of several transfer channels may use one shared data-movement path. Channels raise a request bit. When the path is free, the arbiter picks one requester by rotating priority and registers a one-hot grant, a grant-valid flag and the index of the winner. A grant is not re-arbitrated on every beat. It stays with its owner until that owner raises its release (done) bit. A channel must hold a grant before it starts any transfer on the shared path.

Each channel also has a lock input. If the owner's lock is high at the moment it releases, the arbiter reserves the path for that channel. No other channel is granted until the owner's lock is seen low in a cycle with no grant. While the reservation lasts, the reserved channel may be granted again. The lock is only examined at release and while the path is reserved, so dropping it in the middle of a grant never forces a new grant.

Top module: `rr_lock_arb`

## Requirements
- R1: After reset, no grant is asserted, `gnt_vld_o` is 0, and the rotating search starts at channel 0.
- R2: When no grant is held, requests sampled at a clock edge produce a registered grant at that same edge. `gnt_o` is one-hot, `gnt_vld_o` is 1 and `gnt_idx_o` holds the bit position of the winner.
- R3: The search for a new grant starts at the channel after the one most recently released, wrapping from channel N_CH-1 to channel 0, and takes the first requester it finds.
- R4: A grant does not change while its owner keeps its done bit low. Requests, done bits and lock bits of other channels have no effect on it.
- R5: When the owner's done bit is sampled high, the grant drops at that edge. A new grant appears at the following edge at the earliest.
- R6: While no channel requests and no grant is held, no grant is issued and the rotating start point does not move.
- R7: If the owner's lock bit is high when it releases, no other channel is granted while that lock stays high. The reserved channel is granted again when it requests. Lock bits of channels that do not hold the grant are ignored.
- R8: Dropping the owner's lock during a grant does not end or change the grant. A release with the lock low returns to normal rotating arbitration.
- R9: While the path is reserved with no grant held, a low lock bit from the reserved channel clears the reservation at that edge without issuing a grant. Rotating arbitration resumes at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_CH | Per-channel access request |
| done_i | input | N_CH | Per-channel release; only the owner's bit counts |
| lock_i | input | N_CH | Per-channel exclusive-hold request; only the owner's or reserved channel's bit counts |
| gnt_o | output | N_CH | One-hot grant |
| gnt_vld_o | output | 1 | A grant is held |
| gnt_idx_o | output | $clog2(N_CH) | Index of the granted channel |

## Verification
The bench raises release and request on the same cycle to check for a gap cycle. A design that regranted in the release cycle would show no idle cycle, and one that lost the request would never grant. It leaves long idle stretches between a release and the next request, so that a pointer that drifts or resets while idle would send the grant to the wrong channel. It raises lock on bystanders, drops lock in the middle of a grant and toggles lock during a reservation. A design that read the wrong lock bit would either stall the path or let another channel in, and one that reacted to lock immediately would cut a grant short. It also raises done from non-owners while a grant is held, which a design that ORed all done bits would treat as a release.

// File: rtl/rr_lock_arb.sv
module rr_lock_arb #(
  parameter int N_CH = 4,
  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] done_i,
  input  logic [N_CH-1:0] lock_i,
  output logic [N_CH-1:0] gnt_o,
  output logic            gnt_vld_o,
  output logic [IW-1:0]   gnt_idx_o
);

  logic          busy_q;
  logic          rsv_q;
  logic [IW-1:0] own_q;
  logic [IW-1:0] ptr_q;
  logic          pick_ok;
  logic [IW-1:0] pick_idx;
  logic [IW-1:0] own_nx;

  assign own_nx = (own_q == IW'(N_CH - 1)) ? '0 : own_q + 1'b1;

  always_comb begin
    int c;
    pick_ok  = 1'b0;
    pick_idx = '0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      c = int'(ptr_q) + k;
      if (c >= N_CH) c = c - N_CH;
      if (req_i[c]) begin
        pick_ok  = 1'b1;
        pick_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rsv_q  <= 1'b0;
      own_q  <= '0;
      ptr_q  <= '0;
    end else if (busy_q) begin
      if (done_i[own_q]) begin
        busy_q <= 1'b0;
        ptr_q  <= own_nx;
        rsv_q  <= lock_i[own_q];
      end
    end else if (rsv_q) begin
      if (!lock_i[own_q])    rsv_q  <= 1'b0;
      else if (req_i[own_q]) busy_q <= 1'b1;
    end else if (pick_ok) begin
      busy_q <= 1'b1;
      own_q  <= pick_idx;
    end
  end

  assign gnt_o     = busy_q ? (N_CH'(1) << own_q) : '0;
  assign gnt_vld_o = busy_q;
  assign gnt_idx_o = own_q;

endmodule

// File: rtl/rr_lock_arb_chk.sv
module rr_lock_arb_chk #(
  parameter int N_CH = 4,
  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] req_i,
  input logic [N_CH-1:0] done_i,
  input logic [N_CH-1:0] lock_i,
  input logic [N_CH-1:0] gnt_o,
  input logic            gnt_vld_o,
  input logic [IW-1:0]   gnt_idx_o
);

  logic            rsv;
  logic [N_CH-1:0] rsv_own;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv     <= 1'b0;
      rsv_own <= '0;
    end else if (gnt_vld_o && |(gnt_o & done_i)) begin
      rsv     <= |(gnt_o & lock_i);
      rsv_own <= gnt_o;
    end else if (!gnt_vld_o && rsv && !(|(rsv_own & lock_i))) begin
      rsv <= 1'b0;
    end
  end

  // R2
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o) && (gnt_vld_o == (gnt_o != '0)));

  // R2
  idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> gnt_o[gnt_idx_o]);

  // R2
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_vld_o) |-> (($past(req_i) & gnt_o) != '0));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o && !(|(gnt_o & done_i)) |=> gnt_vld_o && $stable(gnt_o));

  // R5
  release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o && |(gnt_o & done_i) |=> !gnt_vld_o);

  // R6
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld_o && (req_i == '0) |=> !gnt_vld_o);

  // R7
  reserved_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv && gnt_vld_o |-> gnt_o == rsv_own);

endmodule

bind rr_lock_arb rr_lock_arb_chk #(.N_CH(N_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i), .lock_i(lock_i),
  .gnt_o(gnt_o), .gnt_vld_o(gnt_vld_o), .gnt_idx_o(gnt_idx_o)
);

// File: tb/rr_lock_arb_tb_top.sv
module rr_lock_arb_tb_top;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, done = '0, lock = '0;
  logic [N-1:0] gnt;
  logic gnt_vld;
  logic [IW-1:0] gnt_idx;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit fin = 1'b0;

  typedef struct { int at; int idx; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  rr_lock_arb #(.N_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done), .lock_i(lock),
    .gnt_o(gnt), .gnt_vld_o(gnt_vld), .gnt_idx_o(gnt_idx)
  );

  function automatic void cmp(int e, string tag);
    logic [N-1:0] eg;
    bit ok;
    eg = (e < 0) ? '0 : (N'(1) << e);
    ok = (gnt === eg) && (gnt_vld === (e >= 0)) && ((e < 0) || (int'(gnt_idx) == e));
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d: gnt=%b vld=%b idx=%0d expected gnt=%b vld=%0d",
               tag, cyc, gnt, gnt_vld, gnt_idx, eg, (e >= 0));
    end
  endfunction

  always @(posedge clk) begin
    #1;
    cyc++;
    while (sb.size() > 0 && sb[0].at == cyc) begin
      exp_t it;
      it = sb.pop_front();
      cmp(it.idx, it.tag);
    end
  end

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] d,
                      input logic [N-1:0] l, input int e, input string tag);
    exp_t it;
    req = r; done = d; lock = l;
    it.at = cyc + 1; it.idx = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    cmp(-1, "R1 reset");
    rst_n = 1'b1;
    step(4'b0000, 4'b0000, 4'b0000, -1, "R6 idle");
    step(4'b0000, 4'b0000, 4'b0000, -1, "R6 idle");
    step(4'b1010, 4'b0000, 4'b0000,  1, "R1 R2 first grant from ch0 search");
    step(4'b1110, 4'b1100, 4'b1000,  1, "R4 others ignored");
    step(4'b1010, 4'b0000, 4'b0000,  1, "R4 hold");
    step(4'b1010, 4'b0010, 4'b0000, -1, "R5 release drop");
    step(4'b1010, 4'b0000, 4'b0000,  3, "R3 search after released");
    step(4'b0000, 4'b1000, 4'b0000, -1, "R5 release ch3");
    step(4'b0001, 4'b0000, 4'b0000,  0, "R3 wrap to ch0");
    step(4'b0000, 4'b0001, 4'b0000, -1, "R5 release ch0");
    step(4'b0000, 4'b0000, 4'b0000, -1, "R6 idle");
    step(4'b0000, 4'b0000, 4'b0000, -1, "R6 idle");
    step(4'b0000, 4'b0000, 4'b0000, -1, "R6 idle");
    step(4'b1001, 4'b0000, 4'b0000,  3, "R6 pointer kept");
    step(4'b0001, 4'b1000, 4'b0000, -1, "R5 release ch3");
    step(4'b0001, 4'b0000, 4'b0000,  0, "R2 grant ch0");
    step(4'b0110, 4'b0000, 4'b0001,  0, "R4 lock while held");
    step(4'b0110, 4'b0001, 4'b0001, -1, "R7 locked release");
    step(4'b0110, 4'b0000, 4'b0001, -1, "R7 reserved");
    step(4'b0110, 4'b0000, 4'b0001, -1, "R7 reserved");
    step(4'b0110, 4'b0000, 4'b0001, -1, "R7 reserved");
    step(4'b0111, 4'b0000, 4'b0001,  0, "R7 owner regrant");
    step(4'b0110, 4'b0001, 4'b0001, -1, "R7 locked release again");
    step(4'b0110, 4'b0000, 4'b0000, -1, "R9 unlock no grant");
    step(4'b0110, 4'b0000, 4'b0000,  1, "R9 resume after owner");
    step(4'b0100, 4'b0000, 4'b0010,  1, "R8 lock held");
    step(4'b0100, 4'b0000, 4'b0000,  1, "R8 unlock mid grant");
    step(4'b0100, 4'b0000, 4'b0000,  1, "R8 unlock mid grant");
    step(4'b0100, 4'b0010, 4'b0000, -1, "R8 unlocked release");
    step(4'b0100, 4'b0000, 4'b0000,  2, "R8 normal arbitration");
    step(4'b1000, 4'b0100, 4'b1000, -1, "R7 bystander lock ignored");
    step(4'b1000, 4'b0000, 4'b1000,  3, "R7 bystander lock ignored");
    step(4'b0000, 4'b1000, 4'b0000, -1, "R5 release ch3");
    step(4'b0000, 4'b0000, 4'b0000, -1, "R6 idle");
    @(negedge clk);
    @(negedge clk);
    fin = 1'b1;
  end

  initial begin
    fork
      wait (fin);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    if (sb.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule